// File: doc/BRIEF.md
# Presettable Decade Counter with Cascade Carry

A single four-bit decimal digit counter that steps through 0 to 9 and wraps back to 0. It can be preset from a parallel data input at any clock edge, cleared by an active-low reset, and gated by two count enables. One enable only gates counting. The other gates counting and also gates the carry output, so several digits can share one clock and be chained into a wider decimal counter: each digit's carry drives the carry-gating enable of the next more significant digit.

A build-time parameter picks the reset style. The reset can clear the digit at once, independent of the clock. It can also clear it only at the next rising edge. The second style lets a decode of the count drive the reset, which gives a glitch-free counter of any modulus below ten. Any four-bit code can be preset, including the six codes above 9. From those codes the digit returns to the decimal sequence within two counting edges along fixed paths.

Top module: `decade_counter`

## Requirements
- R1: With ASYNC_RST=1, a low rst_n forces q to 0 immediately, without waiting for a clock edge.
- R2: With ASYNC_RST=0, a low rst_n leaves q unchanged until the next rising edge of clk, and that edge sets q to 0.
- R3: When load_n is low at a rising edge (and reset is not active), q takes din, with din[0] as the least significant bit. This applies to every 4-bit value and overrides both enables.
- R4: When load_n, en_par and en_trk are all high at a rising edge, q steps as follows: a value from 0 to 8 goes up by one, and 9 goes to 0.
- R5: With load_n high, q holds its value at a rising edge if en_par is low or en_trk is low.
- R6: carry is combinational and equals en_trk AND q[0] AND q[3]. It is high in state 9 (and in codes 11, 13 and 15), and it does not depend on en_par or load_n.
- R7: Counting from a code above 9 follows fixed paths: 10 to 11 to 6, 12 to 13 to 4, and 14 to 15 to 2. So the digit is back in 0..9 after at most two counting edges.
- R8: Reset takes priority over load, load takes priority over counting, and counting takes priority over holding.
- R9: Three digits in a chain, each en_trk fed by the previous digit's carry, count decimal 000 through 999 and roll over to 000.
- R10: With ASYNC_RST=0, tying rst_n low whenever q equals 4 gives a repeating count 0,1,2,3,4 of modulus five.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low clear; asynchronous or synchronous per ASYNC_RST |
| load_n | input | 1 | Active-low parallel preset strobe |
| en_par | input | 1 | Count enable that does not affect carry |
| en_trk | input | 1 | Count enable that also gates carry |
| din | input | 4 | Preset value, bit 0 least significant |
| q | output | 4 | Current digit value |
| carry | output | 1 | Look-ahead carry for the next digit |

## Verification
The hardest states to reach from the ports are the six codes above 9, because normal counting never enters them. The bench reaches each one by presetting it directly and then follows it for two counting edges to confirm the escape path. The hundreds-digit rollover needs a thousand consecutive counting edges through two chained carries, so a three-digit chain runs the whole span and is compared against a plain decimal count. The difference between the two reset styles is checked by dropping reset in the middle of a cycle and sampling q before the next edge.

// File: rtl/decctr_pkg.sv
package decctr_pkg;

    localparam int DIGIT_W = 4;
    localparam logic [DIGIT_W-1:0] TOP_CODE = DIGIT_W'(9);

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } op_e;

    typedef struct packed {
        digit_t val;
    } cnt_s;

endpackage

// File: rtl/decctr_ctrl.sv
module decctr_ctrl
    import decctr_pkg::*;
(
    input  logic clr_i,
    input  logic load_n_i,
    input  logic run_p_i,
    input  logic run_t_i,
    output op_e  op_o
);

    // Fixed priority: clear, preset, count, hold (R8)
    always_comb begin
        if (clr_i) begin
            op_o = OP_CLEAR;
        end else if (!load_n_i) begin
            op_o = OP_LOAD;
        end else if (run_p_i && run_t_i) begin
            op_o = OP_COUNT;
        end else begin
            op_o = OP_HOLD;
        end
    end

endmodule

// File: rtl/decctr_step.sv
module decctr_step
    import decctr_pkg::*;
(
    input  digit_t cur_i,
    output digit_t nxt_o
);

    digit_t tog;

    // Toggle-enable successor; also defines the escape from codes 10..15 (R7)
    always_comb begin
        tog[0] = 1'b1;
        tog[1] = cur_i[0] & ~cur_i[3];
        tog[2] = cur_i[0] & cur_i[1];
        tog[3] = (cur_i[0] & cur_i[1] & cur_i[2]) | (cur_i[0] & cur_i[3]);
        nxt_o  = cur_i ^ tog;
    end

endmodule

// File: rtl/decctr_carry.sv
module decctr_carry
    import decctr_pkg::*;
(
    input  digit_t cur_i,
    input  logic   en_t_i,
    output logic   carry_o
);

    // Two-bit decode of the top code, gated by the trickle enable (R6)
    assign carry_o = en_t_i & cur_i[0] & cur_i[DIGIT_W-1];

endmodule

// File: rtl/decade_counter.sv
module decade_counter
    import decctr_pkg::*;
#(
    parameter bit ASYNC_RST = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_n,
    input  logic               en_par,
    input  logic               en_trk,
    input  logic [DIGIT_W-1:0] din,
    output logic [DIGIT_W-1:0] q,
    output logic               carry
);

    cnt_s   cnt_d;
    cnt_s   cnt_q;
    digit_t step_val;
    op_e    op;
    logic   clr_sync;

    // In synchronous mode the clear travels through the next-state path
    assign clr_sync = (ASYNC_RST == 1'b0) && !rst_n;

    decctr_ctrl u_ctrl (
        .clr_i    (clr_sync),
        .load_n_i (load_n),
        .run_p_i  (en_par),
        .run_t_i  (en_trk),
        .op_o     (op)
    );

    decctr_step u_step (
        .cur_i (cnt_q.val),
        .nxt_o (step_val)
    );

    decctr_carry u_carry (
        .cur_i   (cnt_q.val),
        .en_t_i  (en_trk),
        .carry_o (carry)
    );

    always_comb begin
        cnt_d = cnt_q;
        unique case (op)
            OP_CLEAR: cnt_d.val = '0;
            OP_LOAD:  cnt_d.val = din;
            OP_COUNT: cnt_d.val = step_val;
            default:  cnt_d.val = cnt_q.val;
        endcase
    end

    generate
        if (ASYNC_RST) begin : g_async
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_d;
                end
            end

            // R1: while reset is held, the digit reads zero at every edge
            a_r1_async_clear: assert property (@(posedge clk)
                !rst_n |-> (q == '0));
        end else begin : g_sync
            always_ff @(posedge clk) begin
                cnt_q <= cnt_d;
            end

            // R2: a low reset at an edge yields zero after that edge
            a_r2_sync_clear: assert property (@(posedge clk)
                !rst_n |=> (q == '0));
        end
    endgenerate

    assign q = cnt_q.val;

    // R3: preset captures din
    a_r3_preset: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> (q == $past(din)));

    // R4: legal codes below the top step up by one
    a_r4_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && en_par && en_trk && (q < TOP_CODE)) |=> (q == DIGIT_W'($past(q) + 1)));

    // R4: the top code wraps to zero
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && en_par && en_trk && (q == TOP_CODE)) |=> (q == '0));

    // R5: any low enable freezes the digit
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !(en_par && en_trk)) |=> $stable(q));

    // R6: carry present at the top code whenever the trickle enable is high
    a_r6_carry_top: assert property (@(posedge clk) disable iff (!rst_n)
        (en_trk && (q == TOP_CODE)) |-> carry);

    // R6: carry absent whenever the trickle enable is low
    a_r6_carry_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !en_trk |-> !carry);

    // R7: an even illegal code steps to the next odd code
    a_r7_even_escape: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && en_par && en_trk && (q > TOP_CODE) && !q[0]) |=> (q == DIGIT_W'($past(q) + 1)));

    // R7: an odd illegal code lands back inside 0..9
    a_r7_odd_escape: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && en_par && en_trk && (q > TOP_CODE) && q[0]) |=> (q <= TOP_CODE));

endmodule

// File: tb/decade_counter_bench.sv
module decade_counter_bench;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // main instance: asynchronous reset
    logic       rst_n = 1'b1, load_n = 1'b1, en_par = 1'b0, en_trk = 1'b0;
    logic [3:0] din = 4'd0, q;
    logic       carry;

    decade_counter #(.ASYNC_RST(1'b1)) u_decade_counter (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_par(en_par),
        .en_trk(en_trk), .din(din), .q(q), .carry(carry));

    // synchronous-reset instance
    logic       s_rst_n = 1'b1, s_load_n = 1'b1;
    logic [3:0] s_din = 4'd0, sq;
    logic       s_carry;

    decade_counter #(.ASYNC_RST(1'b0)) u_sync (
        .clk(clk), .rst_n(s_rst_n), .load_n(s_load_n), .en_par(1'b0),
        .en_trk(1'b0), .din(s_din), .q(sq), .carry(s_carry));

    // modulus-five counter built from the synchronous reset
    logic       m_rst_n = 1'b1;
    logic [3:0] mq;
    logic       m_carry;
    logic       m_clr_n;
    assign m_clr_n = m_rst_n && (mq != 4'd4);

    decade_counter #(.ASYNC_RST(1'b0)) u_mod (
        .clk(clk), .rst_n(m_clr_n), .load_n(1'b1), .en_par(1'b1),
        .en_trk(1'b1), .din(4'd0), .q(mq), .carry(m_carry));

    // three-digit chain
    logic       c_rst_n = 1'b1, c_en = 1'b0;
    logic [3:0] cq0, cq1, cq2;
    logic       cc0, cc1, cc2;

    decade_counter #(.ASYNC_RST(1'b0)) u_dig0 (
        .clk(clk), .rst_n(c_rst_n), .load_n(1'b1), .en_par(1'b1),
        .en_trk(c_en), .din(4'd0), .q(cq0), .carry(cc0));
    decade_counter #(.ASYNC_RST(1'b0)) u_dig1 (
        .clk(clk), .rst_n(c_rst_n), .load_n(1'b1), .en_par(1'b1),
        .en_trk(cc0), .din(4'd0), .q(cq1), .carry(cc1));
    decade_counter #(.ASYNC_RST(1'b0)) u_dig2 (
        .clk(clk), .rst_n(c_rst_n), .load_n(1'b1), .en_par(1'b1),
        .en_trk(cc1), .din(4'd0), .q(cq2), .carry(cc2));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // expected successor under counting, from R4 and R7
    function automatic int succ(input int v);
        case (v)
            9:  return 0;
            11: return 6;
            13: return 4;
            15: return 2;
            default: return v + 1;
        endcase
    endfunction

    task automatic preset(input int v);
        load_n = 1'b0; en_par = 1'b0; en_trk = 1'b0; din = 4'(v);
        tick();
        load_n = 1'b1;
    endtask

    initial begin
        #2;
        rst_n = 1'b0; s_rst_n = 1'b0; m_rst_n = 1'b0; c_rst_n = 1'b0;
        tick();
        chk("R1 reset state", q, 0);
        chk("R2 reset state", sq, 0);
        chk("R6 carry in reset", carry, 0);
        rst_n = 1'b1; s_rst_n = 1'b1; m_rst_n = 1'b1; c_rst_n = 1'b1;

        // R3: every code presets, even with both enables high
        for (int v = 0; v < 16; v++) begin
            load_n = 1'b0; en_par = 1'b1; en_trk = 1'b1; din = 4'(v);
            tick();
            chk("R3 preset", q, v);
        end

        // R4 / R7: one counting edge from every code
        for (int v = 0; v < 16; v++) begin
            preset(v);
            en_par = 1'b1; en_trk = 1'b1;
            tick();
            chk("R4 R7 single step", q, succ(v));
        end

        // R7: two-edge escape paths from illegal codes
        for (int v = 10; v < 16; v += 2) begin
            preset(v);
            en_par = 1'b1; en_trk = 1'b1;
            tick();
            chk("R7 first escape edge", q, v + 1);
            tick();
            chk("R7 second escape edge", q, succ(v + 1));
        end

        // R6: carry across all codes and enable combinations, no edges crossed
        for (int v = 0; v < 16; v++) begin
            for (int et = 0; et < 2; et++) begin
                for (int ep = 0; ep < 2; ep++) begin
                    preset(v);
                    en_trk = et[0]; en_par = ep[0];
                    load_n = 1'b0; din = 4'(15 - v);
                    #1;
                    chk("R6 carry load low", carry, et & v & (v >> 3) & 1);
                    load_n = 1'b1;
                    #1;
                    chk("R6 carry load high", carry, et & v & (v >> 3) & 1);
                    en_par = 1'b0; en_trk = 1'b0;
                end
            end
        end

        // R5: hold under each disabling enable pattern
        preset(3);
        for (int m = 0; m < 3; m++) begin
            en_par = (m == 1); en_trk = (m == 0);
            for (int k = 0; k < 3; k++) begin
                tick();
                chk("R5 hold", q, 3);
            end
        end

        // R4: continuous counting through several wraps, with carry at 9
        preset(0);
        en_par = 1'b1; en_trk = 1'b1;
        for (int k = 1; k <= 25; k++) begin
            tick();
            chk("R4 sweep", q, k % 10);
            chk("R6 sweep carry", carry, (k % 10) == 9);
        end

        // R1: mid-cycle clear without a clock edge
        preset(5);
        chk("R3 preset before clear", q, 5);
        #2;
        rst_n = 1'b0;
        #1;
        chk("R1 immediate clear", q, 0);
        // R8: reset dominates preset and count
        load_n = 1'b0; din = 4'd7; en_par = 1'b1; en_trk = 1'b1;
        tick();
        chk("R8 reset over preset", q, 0);
        rst_n = 1'b1; load_n = 1'b1; en_par = 1'b0; en_trk = 1'b0;

        // R2: synchronous clear waits for the edge
        s_load_n = 1'b0; s_din = 4'd7;
        tick();
        chk("R3 sync preset", sq, 7);
        s_rst_n = 1'b0; s_din = 4'd5;
        #2;
        chk("R2 no clear before edge", sq, 7);
        tick();
        chk("R2 R8 clear at edge over preset", sq, 0);
        s_rst_n = 1'b1; s_load_n = 1'b1;

        // R10: modulus five
        m_rst_n = 1'b0;
        tick();
        m_rst_n = 1'b1;
        for (int k = 0; k < 20; k++) begin
            chk("R10 modulus five", mq, k % 5);
            tick();
        end

        // R9: three-digit chain full span
        c_rst_n = 1'b0;
        tick();
        c_rst_n = 1'b1; c_en = 1'b1;
        for (int k = 0; k <= 1001; k++) begin
            chk("R9 chain value", cq2 * 100 + cq1 * 10 + cq0, k % 1000);
            tick();
        end
        c_en = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule